// File: doc/BRIEF.md
# Rack-Granular Reorder Buffer

This block keeps micro-ops in program order between rename and retirement. Its storage is a ring of racks. A rack holds up to `RACK_SLOTS` simple micro-ops, or one heavy micro-op. Rename offers a bundle of up to `ALLOC_W` micro-ops each cycle, and each slot of the bundle is marked simple or heavy. The block places every slot into a rack and a position inside that rack, and returns a tag for each slot. Execution units later report completion by sending that tag back on one of `WB_PORTS` writeback ports.

Space comes back one whole rack at a time. A rack leaves from the head of the ring only after every micro-op in it has completed. Each cycle, up to `RETIRE_RACKS` consecutive complete racks leave from the head. The block reports how many racks and how many micro-ops leave that cycle. If a bundle needs more new racks than are free, rename is stalled and the whole bundle waits. A flush input empties the structure in one cycle.

Top module: `rack_rob`

## Requirements
- R1: A bundle is taken in slot order: the lowest-index valid slot is the oldest. The tag of each slot is {rack index, position in rack}. The position is the low `$clog2(RACK_SLOTS)` bits and the rack index is above them. Tags are valid in the same cycle as the bundle, whenever the bundle is accepted.
- R2: A simple micro-op joins the youngest rack at the next free position when all of the following hold: that rack holds fewer than `RACK_SLOTS` micro-ops, it holds no heavy micro-op, and it is not retiring in this cycle. Otherwise the micro-op opens the next rack at the tail, at position 0.
- R3: A heavy micro-op always opens a new rack at position 0, and that rack stays closed to later micro-ops.
- R4: `alloc_stall` is high when flush is high, or when the bundle needs more new racks than are currently free. A stalled bundle takes no storage and consumes no tags.
- R5: A writeback marks its micro-op complete. A rack retires only when all its micro-ops are complete. Retirement starts at the head and stops at the first rack that is incomplete, so completed younger racks wait behind it.
- R6: At most `RETIRE_RACKS` racks retire per cycle. `retire_ops` is the total number of micro-ops held in the racks that retire.
- R7: Space is reclaimed per rack. A retiring rack returns exactly one rack of space, whatever number of micro-ops it held, and that space can be used from the next cycle.
- R8: Flush empties the buffer in one cycle. In the next cycle nothing retires, and the first micro-op accepted gets tag 0.
- R9: After reset the buffer is empty: no stall for a bundle that fits, no retirement, and allocation starts at rack 0 position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer at the next edge |
| alloc_valid | input | ALLOC_W | Valid bit per bundle slot |
| alloc_heavy | input | ALLOC_W | Per slot: 1 = heavy micro-op (whole rack), 0 = simple |
| alloc_stall | output | 1 | Bundle not accepted this cycle |
| alloc_tag | output | ALLOC_W*TAG_W | Tag per slot, slot i at bits [i*TAG_W +: TAG_W] |
| wb_valid | input | WB_PORTS | Completion report valid per port |
| wb_tag | input | WB_PORTS*TAG_W | Tag of the completed micro-op per port |
| retire_racks | output | $clog2(RETIRE_RACKS+1) | Racks retiring this cycle |
| retire_ops | output | $clog2(RETIRE_RACKS*RACK_SLOTS+1) | Micro-ops retiring this cycle |

## Verification
The bench builds the block with 8 racks, 7 positions per rack, a 9-wide bundle, 2 writeback ports and a retire limit of 3 racks. With only 8 racks, a burst of heavy micro-ops fills the ring within one bundle, so the full-buffer stall and the rack-by-rack release of space are easy to reach. A limit of 3 lets a directed drain complete 4 racks at once, so the per-cycle cap clearly cuts retirement short. Random bundles with sparse heavy ops, rare flushes and partial writebacks then exercise packing across bundles, packing into a rack that is retiring, and the ring wrapping around.

// File: rtl/rack_rob_pkg.sv
package rack_rob_pkg;

   // Population count of up to 16 bits; rack widths are limited to this.
   function automatic logic [4:0] ones16(input logic [15:0] v);
      logic [4:0] c;
      c = '0;
      for (int i = 0; i < 16; i++) begin
         c = c + {4'd0, v[i]};
      end
      return c;
   endfunction

endpackage

// File: rtl/rack_rob_pack.sv
// Assigns rack and position to each slot of an allocation bundle.
module rack_rob_pack #(
   parameter int ALLOC_W    = 9,
   parameter int RACK_SLOTS = 7,
   parameter int RACK_AW    = 5,
   parameter int SLOT_W     = 3,
   parameter int FILL_W     = 3,
   parameter int NEW_W      = 4
) (
   input  logic [ALLOC_W-1:0]         in_valid,
   input  logic [ALLOC_W-1:0]         in_heavy,
   input  logic [RACK_AW-1:0]         tail_ptr,
   input  logic                       tail_open,
   input  logic [FILL_W-1:0]          tail_fill,
   output logic [ALLOC_W*RACK_AW-1:0] slot_rack,
   output logic [ALLOC_W*SLOT_W-1:0]  slot_pos,
   output logic [NEW_W-1:0]           new_racks
);

   always_comb begin
      logic [RACK_AW-1:0] cur_rack;
      logic [RACK_AW-1:0] nxt;
      logic               open;
      logic [FILL_W-1:0]  fill;
      logic [NEW_W-1:0]   n;
      cur_rack  = tail_ptr - 1'b1;
      nxt       = tail_ptr;
      open      = tail_open;
      fill      = tail_fill;
      n         = '0;
      slot_rack = '0;
      slot_pos  = '0;
      for (int i = 0; i < ALLOC_W; i++) begin
         if (in_valid[i]) begin
            if (in_heavy[i]) begin
               slot_rack[i*RACK_AW +: RACK_AW] = nxt;
               slot_pos[i*SLOT_W +: SLOT_W]    = '0;
               nxt  = nxt + 1'b1;
               n    = n + 1'b1;
               open = 1'b0;
            end else if (open && (fill < FILL_W'(RACK_SLOTS))) begin
               slot_rack[i*RACK_AW +: RACK_AW] = cur_rack;
               slot_pos[i*SLOT_W +: SLOT_W]    = SLOT_W'(fill);
               fill = fill + 1'b1;
            end else begin
               slot_rack[i*RACK_AW +: RACK_AW] = nxt;
               slot_pos[i*SLOT_W +: SLOT_W]    = '0;
               cur_rack = nxt;
               nxt      = nxt + 1'b1;
               n        = n + 1'b1;
               open     = 1'b1;
               fill     = FILL_W'(1);
            end
         end
      end
      new_racks = n;
   end

endmodule

// File: rtl/rack_rob_drain.sv
// Finds the run of complete racks at the head, limited per cycle.
module rack_rob_drain #(
   parameter int NUM_RACKS    = 32,
   parameter int RETIRE_RACKS = 8,
   parameter int RACK_AW      = 5,
   parameter int OCC_W        = 6,
   parameter int FILL_W       = 3,
   parameter int RR_W         = 4,
   parameter int RO_W         = 6
) (
   input  logic [RACK_AW-1:0]          head,
   input  logic [OCC_W-1:0]            occ,
   input  logic [NUM_RACKS-1:0]        rack_done,
   input  logic [NUM_RACKS*FILL_W-1:0] rack_cnt,
   output logic [RR_W-1:0]             ret_racks,
   output logic [RO_W-1:0]             ret_ops,
   output logic [NUM_RACKS-1:0]        ret_mask
);

   always_comb begin
      logic               go;
      logic [RACK_AW-1:0] idx;
      go        = 1'b1;
      ret_racks = '0;
      ret_ops   = '0;
      ret_mask  = '0;
      for (int k = 0; k < RETIRE_RACKS; k++) begin
         idx = head + RACK_AW'(k);
         if (go && (OCC_W'(k) < occ) && rack_done[idx]) begin
            ret_racks     = ret_racks + 1'b1;
            ret_ops       = ret_ops + RO_W'(rack_cnt[idx*FILL_W +: FILL_W]);
            ret_mask[idx] = 1'b1;
         end else begin
            go = 1'b0;
         end
      end
   end

endmodule

// File: rtl/rack_rob.sv
// Reorder buffer organised as racks of micro-ops, reclaimed per rack.
module rack_rob
   import rack_rob_pkg::*;
#(
   parameter int ALLOC_W      = 9,
   parameter int RACK_SLOTS   = 7,
   parameter int NUM_RACKS    = 32,
   parameter int RETIRE_RACKS = 8,
   parameter int WB_PORTS     = 4,
   localparam int RACK_AW     = $clog2(NUM_RACKS),
   localparam int SLOT_W      = $clog2(RACK_SLOTS),
   localparam int TAG_W       = RACK_AW + SLOT_W,
   localparam int RR_W        = $clog2(RETIRE_RACKS + 1),
   localparam int RO_W        = $clog2(RETIRE_RACKS * RACK_SLOTS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic [ALLOC_W-1:0]        alloc_valid,
   input  logic [ALLOC_W-1:0]        alloc_heavy,
   output logic                      alloc_stall,
   output logic [ALLOC_W*TAG_W-1:0]  alloc_tag,
   input  logic [WB_PORTS-1:0]       wb_valid,
   input  logic [WB_PORTS*TAG_W-1:0] wb_tag,
   output logic [RR_W-1:0]           retire_racks,
   output logic [RO_W-1:0]           retire_ops
);

   localparam int OCC_W  = $clog2(NUM_RACKS + 1);
   localparam int FILL_W = $clog2(RACK_SLOTS + 1);
   localparam int NEW_W  = $clog2(ALLOC_W + 1);

   // Elaboration-time parameter checks
   if (NUM_RACKS < 2 || (NUM_RACKS & (NUM_RACKS - 1)) != 0) begin : g_bad_racks
      $error("NUM_RACKS must be a power of two, at least 2");
   end
   if (RACK_SLOTS < 2 || RACK_SLOTS > 16) begin : g_bad_slots
      $error("RACK_SLOTS must lie in 2..16");
   end
   if (RETIRE_RACKS < 1 || RETIRE_RACKS > NUM_RACKS) begin : g_bad_retire
      $error("RETIRE_RACKS must lie in 1..NUM_RACKS");
   end
   if (ALLOC_W < 1 || WB_PORTS < 1) begin : g_bad_width
      $error("ALLOC_W and WB_PORTS must be at least 1");
   end

   // Rack state
   logic [RACK_SLOTS-1:0] vmask_q [NUM_RACKS];
   logic [RACK_SLOTS-1:0] done_q  [NUM_RACKS];
   logic [NUM_RACKS-1:0]  heavy_q;
   logic [RACK_AW-1:0]    head_q, tail_q;
   logic [OCC_W-1:0]      occ_q;

   // Per-rack derived status
   logic [NUM_RACKS-1:0]        rack_done;
   logic [NUM_RACKS*FILL_W-1:0] rack_cnt;

   for (genvar g = 0; g < NUM_RACKS; g++) begin : g_rack
      assign rack_cnt[g*FILL_W +: FILL_W] = FILL_W'(ones16(16'(vmask_q[g])));
      assign rack_done[g] = (|vmask_q[g]) &&
                            ((done_q[g] & vmask_q[g]) == vmask_q[g]);
   end

   // Retirement
   logic [NUM_RACKS-1:0] ret_mask;

   rack_rob_drain #(
      .NUM_RACKS(NUM_RACKS), .RETIRE_RACKS(RETIRE_RACKS), .RACK_AW(RACK_AW),
      .OCC_W(OCC_W), .FILL_W(FILL_W), .RR_W(RR_W), .RO_W(RO_W)
   ) u_drain (
      .head(head_q), .occ(occ_q), .rack_done(rack_done), .rack_cnt(rack_cnt),
      .ret_racks(retire_racks), .ret_ops(retire_ops), .ret_mask(ret_mask)
   );

   // Youngest rack: open for packing unless heavy, full or leaving now
   logic [RACK_AW-1:0] youngest;
   logic [FILL_W-1:0]  young_fill;
   logic               tail_open;

   assign youngest   = tail_q - 1'b1;
   assign young_fill = rack_cnt[youngest*FILL_W +: FILL_W];
   assign tail_open  = (occ_q != '0) && !heavy_q[youngest] &&
                       (young_fill < FILL_W'(RACK_SLOTS)) &&
                       (OCC_W'(retire_racks) != occ_q);

   // Allocation
   logic [ALLOC_W*RACK_AW-1:0] slot_rack;
   logic [ALLOC_W*SLOT_W-1:0]  slot_pos;
   logic [NEW_W-1:0]           new_racks;
   logic [OCC_W-1:0]           free_racks;
   logic                       accept;

   rack_rob_pack #(
      .ALLOC_W(ALLOC_W), .RACK_SLOTS(RACK_SLOTS), .RACK_AW(RACK_AW),
      .SLOT_W(SLOT_W), .FILL_W(FILL_W), .NEW_W(NEW_W)
   ) u_pack (
      .in_valid(alloc_valid), .in_heavy(alloc_heavy), .tail_ptr(tail_q),
      .tail_open(tail_open), .tail_fill(young_fill),
      .slot_rack(slot_rack), .slot_pos(slot_pos), .new_racks(new_racks)
   );

   assign free_racks  = OCC_W'(NUM_RACKS) - occ_q;
   assign alloc_stall = flush || (32'(new_racks) > 32'(free_racks));
   assign accept      = (|alloc_valid) && !alloc_stall;

   logic [RACK_AW-1:0] a_rack [ALLOC_W];
   logic [SLOT_W-1:0]  a_pos  [ALLOC_W];

   for (genvar i = 0; i < ALLOC_W; i++) begin : g_slot
      assign a_rack[i] = slot_rack[i*RACK_AW +: RACK_AW];
      assign a_pos[i]  = slot_pos[i*SLOT_W +: SLOT_W];
      assign alloc_tag[i*TAG_W +: TAG_W] = {a_rack[i], a_pos[i]};
   end

   // Writeback decode
   logic [RACK_AW-1:0]  w_rack [WB_PORTS];
   logic [SLOT_W-1:0]   w_pos  [WB_PORTS];
   logic [WB_PORTS-1:0] w_ok;

   for (genvar p = 0; p < WB_PORTS; p++) begin : g_wb
      assign w_pos[p]  = wb_tag[p*TAG_W +: SLOT_W];
      assign w_rack[p] = wb_tag[p*TAG_W + SLOT_W +: RACK_AW];
      assign w_ok[p]   = wb_valid[p] && (32'(w_pos[p]) < RACK_SLOTS);
   end

   // State update: writebacks, then rack release, then new micro-ops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         occ_q   <= '0;
         heavy_q <= '0;
         for (int r = 0; r < NUM_RACKS; r++) begin
            vmask_q[r] <= '0;
            done_q[r]  <= '0;
         end
      end else if (flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         occ_q   <= '0;
         heavy_q <= '0;
         for (int r = 0; r < NUM_RACKS; r++) begin
            vmask_q[r] <= '0;
            done_q[r]  <= '0;
         end
      end else begin
         for (int p = 0; p < WB_PORTS; p++) begin
            if (w_ok[p]) begin
               done_q[w_rack[p]][w_pos[p]] <= 1'b1;
            end
         end
         for (int r = 0; r < NUM_RACKS; r++) begin
            if (ret_mask[r]) begin
               vmask_q[r] <= '0;
               done_q[r]  <= '0;
               heavy_q[r] <= 1'b0;
            end
         end
         if (accept) begin
            for (int i = 0; i < ALLOC_W; i++) begin
               if (alloc_valid[i]) begin
                  vmask_q[a_rack[i]][a_pos[i]] <= 1'b1;
                  done_q[a_rack[i]][a_pos[i]]  <= 1'b0;
                  if (alloc_heavy[i]) begin
                     heavy_q[a_rack[i]] <= 1'b1;
                  end
               end
            end
            tail_q <= tail_q + RACK_AW'(new_racks);
         end
         head_q <= head_q + RACK_AW'(retire_racks);
         occ_q  <= occ_q - OCC_W'(retire_racks) +
                   (accept ? OCC_W'(new_racks) : OCC_W'(0));
      end
   end

endmodule

// File: rtl/rack_rob_chk.sv
// Property checker for rack_rob, attached with bind.
module rack_rob_chk #(
   parameter int NUM_RACKS    = 32,
   parameter int RETIRE_RACKS = 8,
   parameter int RACK_SLOTS   = 7,
   parameter int OCC_W        = 6,
   parameter int RR_W         = 4,
   parameter int RO_W         = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             alloc_stall,
   input logic [RR_W-1:0]  retire_racks,
   input logic [RO_W-1:0]  retire_ops,
   input logic [OCC_W-1:0] occ
);

   a_r4_flush_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> alloc_stall);

   a_r6_rack_cap: assert property (@(posedge clk) disable iff (!rst_n)
      32'(retire_racks) <= RETIRE_RACKS);

   a_r6_ops_range: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(retire_ops) <= 32'(retire_racks) * RACK_SLOTS) &&
      (32'(retire_ops) >= 32'(retire_racks)));

   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0 && retire_racks == '0));

   a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ) <= NUM_RACKS);

   a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> (retire_racks == '0));

endmodule

bind rack_rob rack_rob_chk #(
   .NUM_RACKS(NUM_RACKS), .RETIRE_RACKS(RETIRE_RACKS), .RACK_SLOTS(RACK_SLOTS),
   .OCC_W($clog2(NUM_RACKS + 1)), .RR_W($clog2(RETIRE_RACKS + 1)),
   .RO_W($clog2(RETIRE_RACKS * RACK_SLOTS + 1))
) u_rack_rob_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_stall(alloc_stall),
   .retire_racks(retire_racks), .retire_ops(retire_ops), .occ(occ_q)
);

// File: tb/rack_rob_bench.sv
module rack_rob_bench;

   localparam int AW = 9;
   localparam int RS = 7;
   localparam int NR = 8;
   localparam int RR = 3;
   localparam int WB = 2;
   localparam int TW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fl = 1'b0;
   logic [AW-1:0]   av = '0, ah = '0;
   logic            stall;
   logic [AW*TW-1:0] tags;
   logic [WB-1:0]   wbv = '0;
   logic [WB*TW-1:0] wbt = '0;
   logic [1:0]      rr;
   logic [4:0]      ro;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   // Reference state: per rack masks of occupied and completed positions
   int mv [NR];
   int md [NR];
   int mh [NR];
   int mhead = 0, mtail = 0, mcnt = 0;

   always #5 clk = ~clk;

   rack_rob #(
      .ALLOC_W(AW), .RACK_SLOTS(RS), .NUM_RACKS(NR),
      .RETIRE_RACKS(RR), .WB_PORTS(WB)
   ) u_rack_rob (
      .clk(clk), .rst_n(rst_n), .flush(fl), .alloc_valid(av), .alloc_heavy(ah),
      .alloc_stall(stall), .alloc_tag(tags), .wb_valid(wbv), .wb_tag(wbt),
      .retire_racks(rr), .retire_ops(ro)
   );

   task automatic chk(string lbl, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", lbl, what, act, exp);
      end
   endtask

   function automatic bit full_rack(int r);
      return mv[r] != 0 && ((md[r] & mv[r]) == mv[r]);
   endfunction

   // wmode: 0 none, 1 random pick, 2 use wv/wt as given
   task automatic step(string lbl, logic [AW-1:0] v, logic [AW-1:0] h, bit f,
                       int wmode, logic [WB-1:0] wv, logic [WB*TW-1:0] wt);
      int n, ops, y, cur, fill, nx, nnew;
      bit open, estall, acc;
      int er [AW];
      int es [AW];
      @(negedge clk);
      av = v; ah = h; fl = f;
      if (wmode == 2) begin
         wbv = wv; wbt = wt;
      end else begin
         wbv = '0; wbt = '0;
         if (wmode == 1) begin
            for (int p = 0; p < WB; p++) begin
               if (mcnt > 0 && ($urandom % 4) != 0) begin
                  int r;
                  r = (mhead + int'($urandom % mcnt)) % NR;
                  for (int s = 0; s < RS; s++) begin
                     if (mv[r][s] && !md[r][s] && !wbv[p]) begin
                        wbv[p] = 1'b1;
                        wbt[p*TW +: TW] = TW'(r * 8 + s);
                     end
                  end
               end
            end
         end
      end
      #1;
      // expected retirement
      n = 0; ops = 0;
      for (int k = 0; k < RR; k++) begin
         if (k < mcnt && full_rack((mhead + k) % NR)) begin
            n++;
            ops += $countones(mv[(mhead + k) % NR]);
         end else break;
      end
      // expected packing
      y    = (mtail + NR - 1) % NR;
      open = mcnt > 0 && mh[y] == 0 && $countones(mv[y]) < RS && n != mcnt;
      fill = $countones(mv[y]);
      cur = y; nx = mtail; nnew = 0;
      for (int i = 0; i < AW; i++) begin
         er[i] = 0; es[i] = 0;
         if (v[i]) begin
            if (h[i]) begin
               er[i] = nx; nx = (nx + 1) % NR; nnew++; open = 0;
            end else if (open && fill < RS) begin
               er[i] = cur; es[i] = fill; fill++;
            end else begin
               er[i] = nx; cur = nx; nx = (nx + 1) % NR; nnew++;
               open = 1; fill = 1;
            end
         end
      end
      estall = f || (nnew > NR - mcnt);
      acc    = (v != 0) && !estall;
      chk(lbl, "stall", int'(stall), int'(estall));
      chk(lbl, "retire_racks", int'(rr), n);
      chk(lbl, "retire_ops", int'(ro), ops);
      if (acc) begin
         for (int i = 0; i < AW; i++) begin
            if (v[i]) chk(lbl, $sformatf("tag[%0d]", i),
                          int'(tags[i*TW +: TW]), er[i] * 8 + es[i]);
         end
      end
      @(posedge clk);
      if (f) begin
         for (int r = 0; r < NR; r++) begin
            mv[r] = 0; md[r] = 0; mh[r] = 0;
         end
         mhead = 0; mtail = 0; mcnt = 0;
      end else begin
         for (int p = 0; p < WB; p++) begin
            if (wbv[p]) begin
               int t;
               t = int'(wbt[p*TW +: TW]);
               if (t % 8 < RS) md[t / 8] = md[t / 8] | (1 << (t % 8));
            end
         end
         for (int k = 0; k < n; k++) begin
            mv[(mhead + k) % NR] = 0; md[(mhead + k) % NR] = 0;
            mh[(mhead + k) % NR] = 0;
         end
         mhead = (mhead + n) % NR;
         mcnt -= n;
         if (acc) begin
            for (int i = 0; i < AW; i++) begin
               if (v[i]) begin
                  mv[er[i]] = mv[er[i]] | (1 << es[i]);
                  md[er[i]] = md[er[i]] & ~(1 << es[i]);
                  if (h[i]) mh[er[i]] = 1;
               end
            end
            mtail = (mtail + nnew) % NR;
            mcnt += nnew;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int r = 0; r < NR; r++) begin
         mv[r] = 0; md[r] = 0; mh[r] = 0;
      end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R9: empty after reset
      step("R9 reset idle", '0, '0, 0, 0, '0, '0);
      // R1: full bundle fills rack 0 then opens rack 1
      step("R1 full bundle", 9'h1FF, '0, 0, 0, '0, '0);
      // R2: simple ops pack into the youngest rack
      step("R2 pack youngest", 9'h007, '0, 0, 0, '0, '0);
      // R3: heavy op in the middle closes its own rack
      step("R3 heavy rack", 9'h007, 9'h002, 0, 0, '0, '0);
      // R5: younger racks complete, head incomplete
      step("R5 younger done", '0, '0, 0, 2, 2'b11, {6'd24, 6'd16});
      step("R5 head blocks", '0, '0, 0, 0, '0, '0);
      step("R5 head blocks", '0, '0, 0, 0, '0, '0);
      for (int t = 8; t < 14; t++) step("R5 drain", '0, '0, 0, 2, 2'b01, {6'd0, 6'(t)});
      for (int t = 0; t < 7; t++) step("R5 drain", '0, '0, 0, 2, 2'b01, {6'd0, 6'(t)});
      // R6: four complete racks, at most three per cycle
      step("R6 cap", '0, '0, 0, 0, '0, '0);
      step("R6 cap", '0, '0, 0, 0, '0, '0);
      // R4: fill every rack with heavy ops, then a simple op stalls
      step("R4 fill", 9'h0FF, 9'h0FF, 0, 0, '0, '0);
      step("R4 full stall", 9'h001, '0, 0, 0, '0, '0);
      step("R4 full stall", 9'h001, '0, 0, 0, '0, '0);
      // R7: one rack completes and frees exactly one rack
      step("R7 free one", 9'h003, 9'h002, 0, 2, 2'b01, {6'd0, 6'd32});
      step("R7 free one", 9'h003, 9'h002, 0, 0, '0, '0);
      step("R7 free one", 9'h001, '0, 0, 0, '0, '0);
      step("R7 refill", 9'h001, '0, 0, 0, '0, '0);
      // R8: flush, then first op takes tag 0
      step("R8 flush", 9'h001, '0, 1, 0, '0, '0);
      step("R8 after flush", 9'h001, '0, 0, 0, '0, '0);
      step("R8 after flush", '0, '0, 0, 0, '0, '0);

      // Random traffic
      for (int c = 0; c < 4000; c++) begin
         logic [AW-1:0] v, h;
         bit f;
         v = AW'($urandom);
         if ($urandom % 3 == 0) v = '0;
         h = AW'($urandom & $urandom & $urandom);
         f = ($urandom % 250) == 0;
         step("random R2 R4 R5 R6", v, h, f, 1, '0, '0);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule